// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interprocessor command into the set of agents that should receive it. The system it serves has a fixed number of agents, eight by default. Each agent presents three values: an 8-bit physical ID, an 8-bit logical destination and a 4-bit addressing model. A sender writes a two-word command through a narrow write port, and states its own agent index alongside the command.

The high word only holds the destination byte. Writing the low word launches resolution. One clock later the block presents a registered result: a target mask, the delivery mode, the vector and the trigger flag, marked by a one-cycle valid strobe. In lowest-priority mode the mask holds a single target.

An INIT command with level 0 and trigger 1 delivers nothing to the agents. Instead it raises a separate strobe whose mask names the agents that should reload their arbitration ID from their physical ID. Delivery inside each agent is handled elsewhere.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is high and in the first cycle after it, both strobes (`res_valid`, `res_sync_valid`) are 0, the result mask is 0, and the stored high word is 0.
- R2: A write with `cmd_sel_hi`=1 only stores the word and raises no strobe. A write with `cmd_sel_hi`=0 launches a command. Its fields are: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11 (0 physical, 1 logical), level in bit 14, trigger in bit 15 and shorthand in bits 19:18. The destination is bits 31:24 of the stored high word. One cycle after the launching write, `res_valid` is high for exactly one cycle and carries the vector, mode and trigger of the command.
- R3: Shorthand 1 targets only the sender. Shorthand 2 targets every agent. Shorthand 3 targets every agent except the sender. With any of these the destination field is ignored.
- R4: With shorthand 0 in physical mode, destination 0xFF targets all agents. Any other destination targets the agents whose physical ID equals it, and targets nothing if no ID matches.
- R5: With shorthand 0 in logical mode, an agent with model 0xF matches when the destination ANDed with its logical destination is nonzero.
- R6: With shorthand 0 in logical mode, an agent with model 0x0 matches when the upper nibbles of the destination and its logical destination are equal and the lower nibbles share at least one set bit. An agent with any other model never matches.
- R7: In delivery mode 1 (lowest priority), the result mask holds only the lowest-indexed agent of the target set, or is 0 if the set is empty.
- R8: Delivery mode 5 with level 0 and trigger 1 raises no `res_valid`. Instead `res_sync_valid` pulses for one cycle, with `res_sync_mask` equal to the target set.
- R9: Delivery mode 3 is reserved. It raises neither strobe. Modes 0, 2, 4, 6 and 7, and mode 5 outside R8, deliver the full target set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write enable |
| cmd_sel_hi | input | 1 | 1 selects the high (destination) word, 0 the launching low word |
| cmd_wdata | input | 32 | Command word data |
| sender_idx | input | 3 | Index of the sending agent |
| agent_phys_id | input | 64 | Physical IDs, agent i in bits 8i+7:8i |
| agent_log_dest | input | 64 | Logical destinations, agent i in bits 8i+7:8i |
| agent_model | input | 32 | Addressing models, agent i in bits 4i+3:4i |
| res_valid | output | 1 | One-cycle delivery strobe |
| res_mask | output | 8 | Target agents of the delivery |
| res_mode | output | 3 | Delivery mode of the delivery |
| res_vector | output | 8 | Vector of the delivery |
| res_trigger | output | 1 | Trigger flag of the delivery |
| res_sync_valid | output | 1 | One-cycle arbitration resync strobe |
| res_sync_mask | output | 8 | Agents that reload their arbitration ID |

## Verification
Every result is one register stage away from the launching write. The strobes and the result fields are therefore due in the cycle right after the clock edge that samples the low-word write. They must be gone one edge later. The bench drives each write on a falling edge and holds it for one cycle. It reads the results on the next falling edge, then checks on the following falling edge that the strobe has dropped. Writes to the high word and reserved or resync commands are checked in the same cycle slot, to confirm that no delivery strobe appears.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_SELF  = 2'd1,
    SH_ALL   = 2'd2,
    SH_OTHER = 2'd3
  } short_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int ID_W    = 8,
  parameter int MODEL_W = 4
) (
  input  logic [ID_W-1:0]    dest,
  input  logic               logical,
  input  logic [ID_W-1:0]    phys_id,
  input  logic [ID_W-1:0]    log_dest,
  input  logic [MODEL_W-1:0] model,
  output logic               hit
);
  localparam int HALF = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST = '1;

  logic flat_hit, clus_hit;

  always_comb begin
    flat_hit = (model == irq_dest_pkg::MODEL_FLAT) && ((dest & log_dest) != '0);
    clus_hit = (model == irq_dest_pkg::MODEL_CLUSTER) &&
               (dest[ID_W-1:HALF] == log_dest[ID_W-1:HALF]) &&
               ((dest[HALF-1:0] & log_dest[HALF-1:0]) != '0);
    if (logical) hit = flat_hit || clus_hit;
    else         hit = (dest == BCAST) || (dest == phys_id);
  end
endmodule

// File: rtl/irq_dest_pick.sv
module irq_dest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] set_in,
  output logic [N-1:0] first
);
  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (set_in[i]) first = '0;
      if (set_in[i]) first[i] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int N_AGENTS = 8,
  parameter int ID_W     = 8,
  parameter int MODEL_W  = 4,
  parameter int WORD_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_wr,
  input  logic                          cmd_sel_hi,
  input  logic [WORD_W-1:0]             cmd_wdata,
  input  logic [$clog2(N_AGENTS)-1:0]   sender_idx,
  input  logic [N_AGENTS*ID_W-1:0]      agent_phys_id,
  input  logic [N_AGENTS*ID_W-1:0]      agent_log_dest,
  input  logic [N_AGENTS*MODEL_W-1:0]   agent_model,
  output logic                          res_valid,
  output logic [N_AGENTS-1:0]           res_mask,
  output logic [2:0]                    res_mode,
  output logic [7:0]                    res_vector,
  output logic                          res_trigger,
  output logic                          res_sync_valid,
  output logic [N_AGENTS-1:0]           res_sync_mask
);
  import irq_dest_pkg::*;

  localparam int SIDX_W = $clog2(N_AGENTS);
  localparam logic [N_AGENTS-1:0] ALL_AGENTS = '1;

  logic [WORD_W-1:0]   hi_q;
  logic [ID_W-1:0]     dest;
  logic [N_AGENTS-1:0] addr_hits, target_set, first_set, self_bit;
  logic                launch, dest_logical, is_sync;
  dmode_e              mode;
  short_e              shorthand;

  assign launch       = cmd_wr && !cmd_sel_hi;
  assign dest         = hi_q[DEST_LSB +: ID_W];
  assign dest_logical = cmd_wdata[DMODE_BIT];
  assign mode         = dmode_e'(cmd_wdata[MODE_LSB +: 3]);
  assign shorthand    = short_e'(cmd_wdata[SH_LSB +: 2]);
  assign is_sync      = (mode == DM_INIT) && !cmd_wdata[LEVEL_BIT] && cmd_wdata[TRIG_BIT];
  assign self_bit     = N_AGENTS'(1) << sender_idx;

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (cmd_wr && cmd_sel_hi) hi_q <= cmd_wdata;
  end

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    irq_dest_match #(.ID_W(ID_W), .MODEL_W(MODEL_W)) match_i (
      .dest     (dest),
      .logical  (dest_logical),
      .phys_id  (agent_phys_id[g*ID_W +: ID_W]),
      .log_dest (agent_log_dest[g*ID_W +: ID_W]),
      .model    (agent_model[g*MODEL_W +: MODEL_W]),
      .hit      (addr_hits[g])
    );
  end

  always_comb begin
    unique case (shorthand)
      SH_SELF:  target_set = self_bit;
      SH_ALL:   target_set = ALL_AGENTS;
      SH_OTHER: target_set = ALL_AGENTS & ~self_bit;
      default:  target_set = addr_hits;
    endcase
  end

  irq_dest_pick #(.N(N_AGENTS)) pick_i (
    .set_in (target_set),
    .first  (first_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_mask       <= '0;
      res_mode       <= 3'd0;
      res_vector     <= 8'd0;
      res_trigger    <= 1'b0;
      res_sync_valid <= 1'b0;
      res_sync_mask  <= '0;
    end else begin
      res_valid      <= 1'b0;
      res_sync_valid <= 1'b0;
      if (launch) begin
        if (is_sync) begin
          res_sync_valid <= 1'b1;
          res_sync_mask  <= target_set;
        end else if (mode != DM_RSVD) begin
          res_valid   <= 1'b1;
          res_mask    <= (mode == DM_LOWPRI) ? first_set : target_set;
          res_mode    <= mode;
          res_vector  <= cmd_wdata[VEC_LSB +: 8];
          res_trigger <= cmd_wdata[TRIG_BIT];
        end
      end
    end
  end

  p_strobe_after_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid || res_sync_valid) |-> $past(cmd_wr && !cmd_sel_hi));

  p_other_excludes_self_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(cmd_wdata[SH_LSB +: 2]) == 2'd3) |-> !res_mask[$past(sender_idx)]);

  p_lowpri_single_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mode == 3'd1) |-> $onehot0(res_mask));

  p_sync_no_delivery_r8: assert property (@(posedge clk) disable iff (rst)
    res_sync_valid |-> !res_valid);

  p_reserved_silent_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_mode != 3'd3);

  p_sender_in_range: assert property (@(posedge clk) disable iff (rst)
    launch |-> (int'(sender_idx) < N_AGENTS));

  logic unused_sidx;
  assign unused_sidx = ^SIDX_W;
endmodule

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0, cmd_sel_hi = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [2:0] sender_idx = '0;
  logic [N*8-1:0] agent_phys_id, agent_log_dest;
  logic [N*4-1:0] agent_model;
  logic res_valid, res_trigger, res_sync_valid;
  logic [N-1:0] res_mask, res_sync_mask;
  logic [2:0] res_mode;
  logic [7:0] res_vector;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_resolver dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_sel_hi(cmd_sel_hi),
    .cmd_wdata(cmd_wdata), .sender_idx(sender_idx),
    .agent_phys_id(agent_phys_id), .agent_log_dest(agent_log_dest),
    .agent_model(agent_model), .res_valid(res_valid), .res_mask(res_mask),
    .res_mode(res_mode), .res_vector(res_vector), .res_trigger(res_trigger),
    .res_sync_valid(res_sync_valid), .res_sync_mask(res_sync_mask));

  // Agents 0-2 flat (log 0x01/0x02/0x04), agent 3 model 5 (log 0x08),
  // agents 4-7 cluster (log 0x31,0x32,0x41,0x42). Physical IDs 0x20+i.
  initial begin
    for (int i = 0; i < N; i++) agent_phys_id[i*8 +: 8] = 8'h20 + 8'(i);
    agent_log_dest = {8'h42, 8'h41, 8'h32, 8'h31, 8'h08, 8'h04, 8'h02, 8'h01};
    agent_model    = {4'h0, 4'h0, 4'h0, 4'h0, 4'h5, 4'hF, 4'hF, 4'hF};
  end

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] mode,
      input logic dm, input logic lvl, input logic trg, input logic [1:0] sh);
    return {12'd0, sh, 2'd0, trg, lvl, 2'd0, dm, mode, vec};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_hi(input logic [7:0] dest);
    @(negedge clk);
    cmd_wr = 1; cmd_sel_hi = 1; cmd_wdata = {dest, 24'h0};
    @(negedge clk);
    cmd_wr = 0; cmd_sel_hi = 0;
  endtask

  // Launch, then sample one cycle later and check the strobe lasts one cycle.
  task automatic launch(input string req, input logic [31:0] lo, input logic [2:0] snd,
                        input logic exp_v, input logic [N-1:0] exp_mask,
                        input logic exp_sync);
    @(negedge clk);
    cmd_wr = 1; cmd_sel_hi = 0; cmd_wdata = lo; sender_idx = snd;
    @(negedge clk);
    cmd_wr = 0;
    check(req, "valid", res_valid, exp_v);
    check(req, "sync_valid", res_sync_valid, exp_sync);
    if (exp_v) begin
      check(req, "mask", res_mask, exp_mask);
      check(req, "mode", res_mode, lo[10:8]);
      check(req, "vector", res_vector, lo[7:0]);
      check(req, "trigger", res_trigger, lo[15]);
    end
    if (exp_sync) check(req, "sync_mask", res_sync_mask, exp_mask);
    @(negedge clk);
    check(req, "strobe_drop", {res_valid, res_sync_valid}, 2'b00);
  endtask

  task automatic t_reset;
    check("R1", "valid", res_valid, 0);
    check("R1", "sync_valid", res_sync_valid, 0);
    check("R1", "mask", res_mask, 0);
    // stored high word zero: physical dest 0x00 matches no agent
    launch("R1", lo_word(8'h30, 3'd0, 0, 1, 0, 2'd0), 0, 1, 8'h00, 0);
  endtask

  task automatic t_hi_only;
    @(negedge clk);
    cmd_wr = 1; cmd_sel_hi = 1; cmd_wdata = 32'h2300_0000;
    @(negedge clk);
    cmd_wr = 0;
    check("R2", "hi write no strobe", {res_valid, res_sync_valid}, 2'b00);
    launch("R2", lo_word(8'h41, 3'd0, 0, 1, 1, 2'd0), 0, 1, 8'h08, 0);
  endtask

  task automatic t_shorthand;
    write_hi(8'h23);
    launch("R3", lo_word(8'h50, 3'd0, 0, 1, 0, 2'd1), 5, 1, 8'h20, 0);
    launch("R3", lo_word(8'h51, 3'd4, 0, 1, 0, 2'd2), 5, 1, 8'hFF, 0);
    launch("R3", lo_word(8'h52, 3'd2, 1, 1, 0, 2'd3), 5, 1, 8'hDF, 0);
  endtask

  task automatic t_physical;
    write_hi(8'hFF);
    launch("R4", lo_word(8'h60, 3'd0, 0, 1, 0, 2'd0), 0, 1, 8'hFF, 0);
    write_hi(8'h26);
    launch("R4", lo_word(8'h61, 3'd7, 0, 1, 0, 2'd0), 0, 1, 8'h40, 0);
    write_hi(8'h99);
    launch("R4", lo_word(8'h62, 3'd0, 0, 1, 0, 2'd0), 0, 1, 8'h00, 0);
  endtask

  task automatic t_flat;
    write_hi(8'h05);
    launch("R5", lo_word(8'h70, 3'd0, 1, 1, 0, 2'd0), 0, 1, 8'h05, 0);
  endtask

  task automatic t_cluster;
    write_hi(8'h33);
    launch("R6", lo_word(8'h71, 3'd0, 1, 1, 0, 2'd0), 0, 1, 8'h33, 0);
    write_hi(8'h40);
    launch("R6", lo_word(8'h72, 3'd0, 1, 1, 0, 2'd0), 0, 1, 8'h00, 0);
    write_hi(8'h08);
    launch("R6", lo_word(8'h73, 3'd6, 1, 1, 0, 2'd0), 0, 1, 8'h00, 0);
  endtask

  task automatic t_lowpri;
    write_hi(8'hFF);
    launch("R7", lo_word(8'h80, 3'd1, 0, 1, 0, 2'd0), 0, 1, 8'h01, 0);
    write_hi(8'h42);
    launch("R7", lo_word(8'h81, 3'd1, 1, 1, 0, 2'd0), 0, 1, 8'h02, 0);
    launch("R7", lo_word(8'h82, 3'd1, 0, 1, 0, 2'd3), 0, 1, 8'h02, 0);
  endtask

  task automatic t_init;
    write_hi(8'hFF);
    launch("R8", lo_word(8'h00, 3'd5, 0, 0, 1, 2'd3), 2, 0, 8'hFB, 1);
    launch("R8", lo_word(8'h00, 3'd5, 0, 1, 1, 2'd0), 2, 1, 8'hFF, 0);
  endtask

  task automatic t_reserved;
    write_hi(8'hFF);
    launch("R9", lo_word(8'h90, 3'd3, 0, 1, 0, 2'd0), 0, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "in reset valid", res_valid, 0);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_hi_only;
    t_shorthand;
    t_physical;
    t_flat;
    t_cluster;
    t_lowpri;
    t_init;
    t_reserved;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule